// File: doc/BRIEF.md
# Lossy Overwriting Message FIFO

This block is a bounded message queue for links between subsystems where the writer and the reader must never stall. Every operation goes through an access strobe. In an access cycle the user raises either the write strobe, together with a data word, or the read strobe.

A write is never refused. When the queue already holds its full number of words, the oldest unread word is dropped to make room for the new one. A read always yields a word. When the queue holds nothing, the block repeats the word it returned last. If no word has been returned since reset, it yields a configurable default word.

The occupancy count and two advisory flags are visible at the ports. The flags tell the user whether a write would be lossless and whether a read would return fresh data. Depth, word width and the default word are parameters.

Top module: `lossy_msg_fifo`

## Requirements
- R1: After synchronous active-high reset, occupancy is 0, the write-allowed flag is 1, the read-allowed flag is 0, and the read data output equals the default word.
- R2: An access cycle with the write strobe, when occupancy is below the depth, raises occupancy by one at the next clock edge.
- R3: An access cycle with the write strobe, when occupancy equals the depth, leaves occupancy at the depth and stores the new word. The oldest unread word is discarded, so the unread words are always the most recent writes, at most depth of them.
- R4: An access cycle with the read strobe, when occupancy is nonzero, places the oldest unread word on the read data output and lowers occupancy by one at the next clock edge.
- R5: An access cycle with the read strobe, when occupancy is zero, leaves occupancy at zero and keeps the read data output at the word returned by the latest successful read.
- R6: A read on an empty queue when no successful read has happened since reset returns the default word.
- R7: The write-allowed flag is 1 exactly when occupancy is below the depth. The read-allowed flag is 1 exactly when occupancy is above zero. Both flags follow the occupancy held before the next access.
- R8: While the access strobe is low, the write and read strobes have no effect. The same holds for an access cycle that carries neither strobe. In both cases occupancy, the flags and the read data output stay unchanged.
- R9: Reads return words in the order they were written.
- R10: The read and write strobes are never raised together in an access cycle. The block's behaviour in that case is undefined, and it is flagged by a property.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| accessStb | input | 1 | Marks an access cycle |
| wrStb | input | 1 | Write request within an access cycle |
| wrData | input | WIDTH | Word to write |
| rdStb | input | 1 | Read request within an access cycle |
| rdData | output | WIDTH | Word returned by the latest read |
| occupancy | output | $clog2(DEPTH+1) | Number of unread words |
| wrAllowed | output | 1 | Occupancy below depth |
| rdAllowed | output | 1 | Occupancy above zero |

## Verification
The hardest case to reach is a read taken after overflow has pushed the read position around the stored window. In that case the word returned must be the oldest surviving write, not the oldest write ever made. The stimulus fills the queue and then overruns it by several words before draining it completely. It then mixes random writes, reads and idle cycles, biased so that occupancy often sits at both the full and the empty limit. A behavioural queue in the bench predicts every output on every clock.

// File: rtl/lossy_fifo_pkg.sv
package lossy_fifo_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;   // push the write word into the window
    logic loadOut;   // capture the selected word as read data
  } fifoStrobes_t;
endpackage

// File: rtl/lossy_fifo_ctrl.sv
module lossy_fifo_ctrl
  import lossy_fifo_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accessStb,
  input  logic             wrStb,
  input  logic             rdStb,
  output fifoStrobes_t     strb,
  output logic [CNT_W-1:0] rdIdx,
  output logic [CNT_W-1:0] count,
  output logic             wrOk,
  output logic             rdOk
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [CNT_W-1:0] cntQ;
  logic             doWr, doRd;

  assign doWr = accessStb & wrStb;
  assign doRd = accessStb & rdStb;
  assign wrOk = (cntQ < FULL);
  assign rdOk = (cntQ != '0);

  assign strb.shiftIn = doWr;
  assign strb.loadOut = doRd & rdOk;
  assign rdIdx        = FULL - cntQ;
  assign count        = cntQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      cntQ <= '0;
    end else if (doWr && wrOk) begin
      cntQ <= cntQ + 1'b1;
    end else if (doRd && rdOk) begin
      cntQ <= cntQ - 1'b1;
    end
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    cntQ <= FULL);

  // R2
  wr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (doWr && wrOk) |=> (cntQ == $past(cntQ) + 1'b1));

  // R4
  rd_step_chk: assert property (@(posedge clk) disable iff (rst)
    (doRd && rdOk) |=> (cntQ == $past(cntQ) - 1'b1));
endmodule

// File: rtl/lossy_fifo_dp.sv
module lossy_fifo_dp
  import lossy_fifo_pkg::*;
#(
  parameter int                 DEPTH        = 4,
  parameter int                 WIDTH        = 8,
  parameter logic [WIDTH-1:0]   DEFAULT_WORD = '0,
  localparam int                CNT_W        = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  fifoStrobes_t     strb,
  input  logic [CNT_W-1:0] rdIdx,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData
);
  // window of recent writes, index DEPTH-1 is the newest
  logic [WIDTH-1:0] win [DEPTH];
  logic [WIDTH-1:0] selWord;
  logic [WIDTH-1:0] outQ;

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_win
      if (g == DEPTH - 1) begin : g_newest
        always_ff @(posedge clk) begin
          if (rst)               win[g] <= '0;
          else if (strb.shiftIn) win[g] <= wrData;
        end
      end else begin : g_older
        always_ff @(posedge clk) begin
          if (rst)               win[g] <= '0;
          else if (strb.shiftIn) win[g] <= win[g+1];
        end
      end
    end
  endgenerate

  always_comb begin
    selWord = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rdIdx == CNT_W'(i)) selWord = win[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)               outQ <= DEFAULT_WORD;
    else if (strb.loadOut) outQ <= selWord;
  end

  assign rdData = outQ;

  // R3
  newest_store_chk: assert property (@(posedge clk) disable iff (rst)
    strb.shiftIn |=> (win[DEPTH-1] == $past(wrData)));
endmodule

// File: rtl/lossy_msg_fifo.sv
module lossy_msg_fifo
  import lossy_fifo_pkg::*;
#(
  parameter int               DEPTH        = 4,
  parameter int               WIDTH        = 8,
  parameter logic [WIDTH-1:0] DEFAULT_WORD = 8'hA5,
  localparam int              CNT_W        = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accessStb,
  input  logic             wrStb,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdStb,
  output logic [WIDTH-1:0] rdData,
  output logic [CNT_W-1:0] occupancy,
  output logic             wrAllowed,
  output logic             rdAllowed
);
  fifoStrobes_t     strb;
  logic [CNT_W-1:0] rdIdx;

  lossy_fifo_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk(clk), .rst(rst), .accessStb(accessStb), .wrStb(wrStb),
    .rdStb(rdStb), .strb(strb), .rdIdx(rdIdx), .count(occupancy),
    .wrOk(wrAllowed), .rdOk(rdAllowed)
  );

  lossy_fifo_dp #(.DEPTH(DEPTH), .WIDTH(WIDTH), .DEFAULT_WORD(DEFAULT_WORD)) i_dp (
    .clk(clk), .rst(rst), .strb(strb), .rdIdx(rdIdx),
    .wrData(wrData), .rdData(rdData)
  );

  // R3
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (accessStb && wrStb && !wrAllowed) |=> (occupancy == CNT_W'(DEPTH)));

  // R5
  empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    (accessStb && rdStb && !rdAllowed) |=> ($stable(rdData) && occupancy == '0));

  // R8
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!accessStb || (!wrStb && !rdStb)) |=> ($stable(rdData) && $stable(occupancy)));

  // R10
  excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(accessStb && wrStb && rdStb));
endmodule

// File: tb/test_lossy_msg_fifo.sv
`timescale 1ns/1ps
module test_lossy_msg_fifo;
  localparam int DEPTH = 4;
  localparam int WIDTH = 8;
  localparam logic [WIDTH-1:0] DEF = 8'hA5;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic accessStb = 1'b0, wrStb = 1'b0, rdStb = 1'b0;
  logic [WIDTH-1:0] wrData = '0;
  logic [WIDTH-1:0] rdData;
  logic [CNT_W-1:0] occupancy;
  logic wrAllowed, rdAllowed;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural reference
  logic [WIDTH-1:0] q [$];
  logic [WIDTH-1:0] lastOut;

  always #2.5 clk = ~clk;

  lossy_msg_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH), .DEFAULT_WORD(DEF)) i_lossy_msg_fifo (
    .clk(clk), .rst(rst), .accessStb(accessStb), .wrStb(wrStb), .wrData(wrData),
    .rdStb(rdStb), .rdData(rdData), .occupancy(occupancy),
    .wrAllowed(wrAllowed), .rdAllowed(rdAllowed)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    check(tag, "rdData", int'(rdData), int'(lastOut));
    check(tag, "occupancy", int'(occupancy), q.size());
    check("R7", "wrAllowed", int'(wrAllowed), int'(q.size() < DEPTH));
    check("R7", "rdAllowed", int'(rdAllowed), int'(q.size() > 0));
  endtask

  // called at a negative edge
  task automatic step(input bit acc, input bit wr, input bit rd,
                      input logic [WIDTH-1:0] d, input string tag);
    accessStb = acc; wrStb = wr; rdStb = rd; wrData = d;
    @(posedge clk);
    if (acc && wr) begin
      if (q.size() == DEPTH) void'(q.pop_front());
      q.push_back(d);
    end else if (acc && rd) begin
      if (q.size() > 0) lastOut = q.pop_front();
    end
    @(negedge clk);
    accessStb = 0; wrStb = 0; rdStb = 0;
    compareAll(tag);
  endtask

  task automatic doReset();
    rst = 1;
    @(posedge clk);
    @(negedge clk);
    rst = 0;
    q.delete();
    lastOut = DEF;
    compareAll("R1");
  endtask

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    doReset();
    // R6: empty read straight after reset gives the default word
    step(1, 0, 1, 8'h00, "R6");
    // R2: partial fill
    step(1, 1, 0, 8'h11, "R2");
    step(1, 1, 0, 8'h22, "R2");
    step(1, 1, 0, 8'h33, "R2");
    // R4: read oldest
    step(1, 0, 1, 8'h00, "R4");
    // fill then overrun by three (R3)
    step(1, 1, 0, 8'h44, "R2");
    step(1, 1, 0, 8'h55, "R2");
    step(1, 1, 0, 8'h66, "R3");
    step(1, 1, 0, 8'h77, "R3");
    step(1, 1, 0, 8'h88, "R3");
    // R9: drain in order, expect 55 66 77 88
    for (int i = 0; i < DEPTH; i++) step(1, 0, 1, 8'h00, "R9");
    // R5: empty reads repeat the last word
    step(1, 0, 1, 8'h00, "R5");
    step(1, 0, 1, 8'h00, "R5");
    // R8: strobes without access, and access without strobes
    step(1, 1, 0, 8'h9A, "R2");
    step(0, 1, 0, 8'hBC, "R8");
    step(0, 0, 1, 8'h00, "R8");
    step(1, 0, 0, 8'hDE, "R8");
    step(1, 0, 1, 8'h00, "R4");
    // small-depth pattern: 4, 6 then reads
    doReset();
    step(1, 1, 0, 8'd4, "R2");
    step(1, 1, 0, 8'd6, "R2");
    step(1, 0, 1, 8'h00, "R9");
    step(1, 0, 1, 8'h00, "R9");
    step(1, 0, 1, 8'h00, "R5");
    // random mix biased towards the limits
    for (int phase = 0; phase < 6; phase++) begin
      for (int n = 0; n < 200; n++) begin
        int r;
        logic [WIDTH-1:0] d;
        r = $urandom_range(0, 99);
        d = WIDTH'($urandom);
        if (r < 10) step(0, r[0], !r[0], d, "R8");
        else if (r < ((phase % 2 == 0) ? 70 : 35))
          step(1, 1, 0, d, (q.size() == DEPTH) ? "R3" : "R2");
        else
          step(1, 0, 1, d, (q.size() == 0) ? "R5" : "R4");
      end
    end
    doReset();
    step(1, 0, 1, 8'h00, "R6");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule